// File: doc/BRIEF.md
# Timer Capture/Compare/PWM Channel

This block is a single channel of a timer. The counter is outside the block. The channel watches the counter's current value, its count direction, a per-count enable strobe and a strobe that marks the counter's reload. A configuration word made of a 2-bit function field and a 2-bit edge/level field turns the channel into one of three things:
- an input capture unit, which latches the counter value on selected edges of a pin that is already synchronised;
- an output compare unit, with several actions taken on a match;
- an edge-aligned or center-aligned PWM generator, with selectable polarity.

The channel has a 16-bit value register, an event flag with an interrupt enable, and one output pin. Software writes the value register on a plain write strobe. Any captured value is visible at once on `chan_val`. Control and status pins are plain, and there is no stream handshake: every write is accepted in the cycle it is presented.

The counter drives `cnt_tick` high for one clock in each cycle where it holds a new count. It raises `cnt_wrap` together with `cnt_tick` on the first count of each period, which is value 0. In up/down operation `cnt_updown` is high and `cnt_down` marks the descending half. In that half the counter presents the values P down to 1, and the rising half presents 0 up to P-1.

Top module: `tmr_chan`

## Requirements
- R1: `cfg_wr` loads the function field `cfg_func` and the edge/level field `cfg_lvl` together in one cycle, and leaves the interrupt enable unchanged. The interrupt enable changes only through `ie_wr`.
- R2: With function 00, edge/level 01 captures on rising edges of `cap_in`, 10 on falling edges, and 11 on both. Edges of the other sense are ignored. Edge/level 00 disables the channel.
- R3: On a capture, the `cnt_val` of that cycle appears on `chan_val` and `chan_flag` rises one clock after the edge is seen. Without a capture or a write, `chan_val` holds.
- R4: With function 01, a counter tick whose `cnt_val` equals the value register sets the flag and acts on `chan_out`. The action depends on edge/level: 00 leaves it unchanged, 01 toggles it, 10 drives it low, and 11 drives it high.
- R5: With function 11, edge/level 10 gives a high pulse and 01 gives a low pulse. Entering the mode drives the opposite (idle) level. A match drives the pulse level, and the next counter tick restores the idle level. The output does not change on cycles without a tick.
- R6: With function 10 and `cnt_updown` low, the channel is an edge-aligned PWM generator. In high-true mode (edge/level 10) the output is driven high at the reload and low on a match. In low-true mode (edge/level 01 or 11) both levels are inverted. Entering PWM drives the inactive level.
- R7: With function 10 and `cnt_updown` high, a match while counting up drives the inactive level and a match while counting down drives the active level. A duty value of d then gives 2d active counts per 2P-count period.
- R8: A duty value of 0 gives a constantly inactive PWM output. A duty value above the top count (edge-aligned), or at or above it (center-aligned), gives a constantly active output.
- R9: In PWM mode a value write goes to a buffer. `chan_val` changes only at the next tick that carries `cnt_wrap`, and that reload tick already compares against the new value.
- R10: `chan_flag` is cleared only by a `flag_clr` pulse. A flag-setting event in the same cycle takes priority over the clear.
- R11: `chan_irq` is high exactly when the flag and the interrupt enable are both set.
- R12: In compare, pulse and PWM modes, `chan_out` changes only on counter ticks or on a configuration write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Shared counter value |
| cnt_tick | input | 1 | Counter holds a new count this cycle |
| cnt_wrap | input | 1 | First count of a period (valid with cnt_tick) |
| cnt_down | input | 1 | Counter in its descending half |
| cnt_updown | input | 1 | Counter runs up/down (selects center alignment) |
| cfg_wr | input | 1 | Load cfg_func and cfg_lvl |
| cfg_func | input | 2 | Function field |
| cfg_lvl | input | 2 | Edge/level field |
| ie_wr | input | 1 | Load interrupt enable |
| ie_in | input | 1 | New interrupt enable |
| val_wr | input | 1 | Write the value register |
| val_in | input | 16 | Value to write |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| cap_in | input | 1 | Synchronised capture pin |
| chan_out | output | 1 | Channel output pin |
| chan_val | output | 16 | Active compare/capture value |
| chan_flag | output | 1 | Channel event flag |
| chan_irq | output | 1 | Interrupt request |

## Verification
The assertions take the following for granted:
- `cnt_wrap` is only ever high together with `cnt_tick`;
- `cnt_tick` is a one-cycle strobe;
- `cap_in` is already synchronised;
- `cnt_down` is meaningful only while `cnt_updown` is high.

The directed tasks produce the counter stream from explicit count sequences. An edge-aligned period is 0..P with the wrap on 0. A center-aligned period is 0..P-1 rising and then P..1 falling. Writes and capture-pin changes are placed in cycles without a tick. This keeps every value and pin change away from a count that could also match.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

  typedef enum logic [2:0] {
    CH_OFF, CH_CAPTURE, CH_COMPARE, CH_PULSE, CH_PWM
  } ch_kind_e;

  // compare action, ordered to match the edge/level field in function 01
  typedef enum logic [1:0] {
    ACT_NONE, ACT_TOGGLE, ACT_CLEAR, ACT_SET
  } cmp_act_e;

  typedef struct packed {
    ch_kind_e kind;
    logic     cap_rise;
    logic     cap_fall;
    cmp_act_e act;
    logic     lvl;   // pulse level or PWM active level
    logic     idle;  // level driven on entering pulse/PWM mode
  } ch_cfg_t;

  function automatic ch_cfg_t decode_mode(input logic [1:0] func, input logic [1:0] lvl);
    ch_cfg_t c;
    c.kind     = CH_OFF;
    c.cap_rise = 1'b0;
    c.cap_fall = 1'b0;
    c.act      = ACT_NONE;
    c.lvl      = 1'b1;
    c.idle     = 1'b0;
    unique case (func)
      2'b00: begin
        if (lvl != 2'b00) c.kind = CH_CAPTURE;
        c.cap_rise = lvl[0];
        c.cap_fall = lvl[1];
      end
      2'b01: begin
        c.kind = CH_COMPARE;
        c.act  = cmp_act_e'(lvl);
      end
      2'b10: begin
        if (lvl != 2'b00) c.kind = CH_PWM;
        c.lvl  = (lvl == 2'b10);
        c.idle = ~c.lvl;
      end
      default: begin
        if (lvl == 2'b10 || lvl == 2'b01) begin
          c.kind = CH_PULSE;
          c.lvl  = lvl[1];
          c.idle = ~lvl[1];
        end else begin
          c.kind = CH_COMPARE;
        end
      end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/tmr_chan_capture.sv
module tmr_chan_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic rise_en,
  input  logic fall_en,
  input  logic pin,
  output logic cap_evt
);
  logic pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin;
  end

  always_comb begin
    cap_evt = armed & ((rise_en & pin & ~pin_q) | (fall_en & ~pin & pin_q));
  end
endmodule

// File: rtl/tmr_chan_value.sv
module tmr_chan_value #(
  parameter int W        = 16,
  parameter bit BUFFERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         cap_evt,
  input  logic [W-1:0] cnt_val,
  input  logic         reload,   // tick carrying the period boundary
  input  logic         pwm,
  output logic [W-1:0] cur,
  output logic [W-1:0] cmp_eff
);
  generate
    if (BUFFERED) begin : g_buf
      logic [W-1:0] shadow;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow <= '0;
          cur    <= '0;
        end else begin
          if (wr)           shadow <= wdata;
          else if (cap_evt) shadow <= cnt_val;

          if (cap_evt)               cur <= cnt_val;
          else if (wr && !pwm)       cur <= wdata;
          else if (pwm && reload)    cur <= shadow;
        end
      end

      always_comb cmp_eff = (pwm && reload) ? shadow : cur;
    end else begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cur <= '0;
        else if (cap_evt) cur <= cnt_val;
        else if (wr)      cur <= wdata;
      end

      always_comb cmp_eff = cur;
    end
  endgenerate
endmodule

// File: rtl/tmr_chan_outgen.sv
module tmr_chan_outgen
  import tmr_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  ch_cfg_t cfg_q,
  input  ch_cfg_t cfg_new,
  input  logic    cfg_wr,
  input  logic    tick,
  input  logic    wrap,
  input  logic    down,
  input  logic    updown,
  input  logic    match,
  output logic    out
);
  logic pend;
  logic going_up;

  always_comb going_up = !(updown && down);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out  <= 1'b0;
      pend <= 1'b0;
    end else if (cfg_wr) begin
      pend <= 1'b0;
      if (cfg_new.kind == CH_PWM || cfg_new.kind == CH_PULSE) out <= cfg_new.idle;
    end else begin
      unique case (cfg_q.kind)
        CH_COMPARE: begin
          if (match) begin
            unique case (cfg_q.act)
              ACT_TOGGLE: out <= ~out;
              ACT_CLEAR:  out <= 1'b0;
              ACT_SET:    out <= 1'b1;
              default:    out <= out;
            endcase
          end
        end
        CH_PULSE: begin
          if (match) begin
            out  <= cfg_q.lvl;
            pend <= 1'b1;
          end else if (tick && pend) begin
            out  <= ~cfg_q.lvl;
            pend <= 1'b0;
          end
        end
        CH_PWM: begin
          if (match && going_up)  out <= ~cfg_q.lvl;
          else if (match)         out <= cfg_q.lvl;
          else if (tick && wrap)  out <= cfg_q.lvl;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_chan_pkg::*;
#(
  parameter int W        = 16,
  parameter bit BUFFERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_tick,
  input  logic         cnt_wrap,
  input  logic         cnt_down,
  input  logic         cnt_updown,
  input  logic         cfg_wr,
  input  logic [1:0]   cfg_func,
  input  logic [1:0]   cfg_lvl,
  input  logic         ie_wr,
  input  logic         ie_in,
  input  logic         val_wr,
  input  logic [W-1:0] val_in,
  input  logic         flag_clr,
  input  logic         cap_in,
  output logic         chan_out,
  output logic [W-1:0] chan_val,
  output logic         chan_flag,
  output logic         chan_irq
);
  ch_cfg_t      cfg_q, cfg_new;
  ch_kind_e     cur_kind;
  logic         ie_q;
  logic         cap_evt;
  logic         match;
  logic         flag_set;
  logic         is_pwm;
  logic         reload;
  logic [W-1:0] cmp_eff;

  always_comb begin
    cfg_new  = decode_mode(cfg_func, cfg_lvl);
    cur_kind = cfg_q.kind;
    is_pwm   = (cfg_q.kind == CH_PWM);
    reload   = cnt_tick && cnt_wrap;
    match    = cnt_tick && (cnt_val == cmp_eff) &&
               (cfg_q.kind inside {CH_COMPARE, CH_PULSE, CH_PWM});
    flag_set = cap_evt | match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= decode_mode(2'b00, 2'b00);
      ie_q      <= 1'b0;
      chan_flag <= 1'b0;
    end else begin
      if (cfg_wr)        cfg_q <= cfg_new;
      if (ie_wr)         ie_q  <= ie_in;
      if (flag_set)      chan_flag <= 1'b1;
      else if (flag_clr) chan_flag <= 1'b0;
    end
  end

  always_comb chan_irq = chan_flag & ie_q;

  tmr_chan_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (cfg_q.kind == CH_CAPTURE),
    .rise_en (cfg_q.cap_rise),
    .fall_en (cfg_q.cap_fall),
    .pin     (cap_in),
    .cap_evt (cap_evt)
  );

  tmr_chan_value #(.W(W), .BUFFERED(BUFFERED)) u_val (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (val_wr),
    .wdata   (val_in),
    .cap_evt (cap_evt),
    .cnt_val (cnt_val),
    .reload  (reload),
    .pwm     (is_pwm),
    .cur     (chan_val),
    .cmp_eff (cmp_eff)
  );

  tmr_chan_outgen u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_q   (cfg_q),
    .cfg_new (cfg_new),
    .cfg_wr  (cfg_wr),
    .tick    (cnt_tick),
    .wrap    (cnt_wrap),
    .down    (cnt_down),
    .updown  (cnt_updown),
    .match   (match),
    .out     (chan_out)
  );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk
  import tmr_chan_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input ch_kind_e     kind,
  input logic         cfg_wr,
  input logic         ie_wr,
  input logic         ie_q,
  input logic         val_wr,
  input logic         cap_evt,
  input logic         flag_set,
  input logic         flag_clr,
  input logic         tick,
  input logic         wrap,
  input logic         chan_out,
  input logic [W-1:0] chan_val,
  input logic         chan_flag,
  input logic         chan_irq
);
  assert_ie_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !ie_wr) |=> $stable(ie_q));

  assert_capture_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CH_CAPTURE && !cap_evt && !val_wr && !cfg_wr) |=> $stable(chan_val));

  assert_buffered_val_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CH_PWM && !(tick && wrap) && !cfg_wr) |=> $stable(chan_val));

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !flag_set) |=> !chan_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_flag && !flag_clr) |=> chan_flag);

  assert_irq_needs_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    chan_irq |-> chan_flag);

  assert_out_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (kind inside {CH_COMPARE, CH_PULSE, CH_PWM} && !tick && !cfg_wr) |=> $stable(chan_out));
endmodule

bind tmr_chan tmr_chan_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .kind      (cur_kind),
  .cfg_wr    (cfg_wr),
  .ie_wr     (ie_wr),
  .ie_q      (ie_q),
  .val_wr    (val_wr),
  .cap_evt   (cap_evt),
  .flag_set  (flag_set),
  .flag_clr  (flag_clr),
  .tick      (cnt_tick),
  .wrap      (cnt_wrap),
  .chan_out  (chan_out),
  .chan_val  (chan_val),
  .chan_flag (chan_flag),
  .chan_irq  (chan_irq)
);

// File: tb/sim_tmr_chan.sv
module sim_tmr_chan;
  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0;
  logic         cnt_tick = 1'b0, cnt_wrap = 1'b0, cnt_down = 1'b0, cnt_updown = 1'b0;
  logic         cfg_wr = 1'b0;
  logic [1:0]   cfg_func = '0, cfg_lvl = '0;
  logic         ie_wr = 1'b0, ie_in = 1'b0;
  logic         val_wr = 1'b0;
  logic [W-1:0] val_in = '0;
  logic         flag_clr = 1'b0, cap_in = 1'b0;
  logic         chan_out, chan_flag, chan_irq;
  logic [W-1:0] chan_val;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  tmr_chan #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick), .cnt_wrap(cnt_wrap),
    .cnt_down(cnt_down), .cnt_updown(cnt_updown), .cfg_wr(cfg_wr), .cfg_func(cfg_func),
    .cfg_lvl(cfg_lvl), .ie_wr(ie_wr), .ie_in(ie_in), .val_wr(val_wr), .val_in(val_in),
    .flag_clr(flag_clr), .cap_in(cap_in), .chan_out(chan_out), .chan_val(chan_val),
    .chan_flag(chan_flag), .chan_irq(chan_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all helpers start and end at a negative edge
  task automatic idle_cyc();
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] f, input logic [1:0] l);
    cfg_wr = 1'b1; cfg_func = f; cfg_lvl = l;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic write_val(input int v);
    val_wr = 1'b1; val_in = W'(v);
    @(negedge clk);
    val_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic tick(input int v, input logic dn, input logic wr);
    cnt_val = W'(v); cnt_tick = 1'b1; cnt_down = dn; cnt_wrap = wr;
    @(negedge clk);
    cnt_tick = 1'b0; cnt_wrap = 1'b0;
  endtask

  // one edge-aligned period 0..top; returns count of samples at level lv
  task automatic edge_period(input int top, input logic lv, output int n);
    n = 0;
    for (int i = 0; i <= top; i++) begin
      tick(i, 1'b0, i == 0);
      if (chan_out == lv) n++;
    end
  endtask

  // one center-aligned period: 0..top-1 rising, top..1 falling
  task automatic center_period(input int top, input logic lv, output int n);
    n = 0;
    for (int i = 0; i < top; i++) begin
      tick(i, 1'b0, i == 0);
      if (chan_out == lv) n++;
    end
    for (int i = top; i >= 1; i--) begin
      tick(i, 1'b1, 1'b0);
      if (chan_out == lv) n++;
    end
  endtask

  task automatic t_reset();
    check("R3 reset val", chan_val, 0);
    check("R10 reset flag", chan_flag, 0);
    check("R11 reset irq", chan_irq, 0);
    check("R12 reset out", chan_out, 0);
  endtask

  task automatic t_capture();
    set_cfg(2'b00, 2'b01);
    cnt_val = 100; cap_in = 1'b1; idle_cyc();
    check("R3 rise capture value", chan_val, 100);
    check("R3 capture flag", chan_flag, 1);
    clear_flag();
    cnt_val = 200; cap_in = 1'b0; idle_cyc(); idle_cyc();
    check("R2 falling ignored in rise mode", chan_val, 100);
    check("R2 no flag on ignored edge", chan_flag, 0);
    set_cfg(2'b00, 2'b10);
    cnt_val = 300; cap_in = 1'b1; idle_cyc(); idle_cyc();
    check("R2 rising ignored in fall mode", chan_val, 100);
    cap_in = 1'b0; idle_cyc();
    check("R2 fall capture", chan_val, 300);
    set_cfg(2'b00, 2'b11);
    cnt_val = 400; cap_in = 1'b1; idle_cyc();
    check("R2 both mode rise", chan_val, 400);
    cnt_val = 500; cap_in = 1'b0; idle_cyc();
    check("R2 both mode fall", chan_val, 500);
    set_cfg(2'b00, 2'b00);
    cnt_val = 600; cap_in = 1'b1; idle_cyc(); cap_in = 1'b0; idle_cyc();
    check("R2 disabled no capture", chan_val, 500);
    clear_flag();
  endtask

  task automatic t_flag_irq();
    set_cfg(2'b00, 2'b01);
    cnt_val = 7; cap_in = 1'b1; idle_cyc();
    check("R11 flag without enable", chan_irq, 0);
    ie_wr = 1'b1; ie_in = 1'b1; idle_cyc(); ie_wr = 1'b0;
    check("R11 irq with enable", chan_irq, 1);
    set_cfg(2'b00, 2'b11);
    check("R1 cfg write keeps enable", chan_irq, 1);
    cap_in = 1'b0; flag_clr = 1'b1; idle_cyc(); flag_clr = 1'b0;
    check("R10 set wins over clear", chan_flag, 1);
    clear_flag();
    check("R10 w1c clears", chan_flag, 0);
    check("R11 irq drops", chan_irq, 0);
    ie_wr = 1'b1; ie_in = 1'b0; idle_cyc(); ie_wr = 1'b0;
  endtask

  task automatic run_to_match(input string req, input int exp_before, input int exp_after);
    for (int i = 0; i < 5; i++) tick(i, 1'b0, i == 0);
    check({req, " before match"}, chan_out, exp_before);
    tick(5, 1'b0, 1'b0);
    check({req, " after match"}, chan_out, exp_after);
    tick(6, 1'b0, 1'b0);
  endtask

  task automatic t_compare();
    write_val(5);
    set_cfg(2'b01, 2'b11);
    run_to_match("R4 set", 0, 1);
    check("R4 match flag", chan_flag, 1);
    clear_flag();
    set_cfg(2'b01, 2'b00);
    run_to_match("R4 none", 1, 1);
    check("R4 none still flags", chan_flag, 1);
    clear_flag();
    set_cfg(2'b01, 2'b01);
    run_to_match("R4 toggle1", 1, 0);
    run_to_match("R4 toggle2", 0, 1);
    set_cfg(2'b01, 2'b10);
    run_to_match("R4 clear", 1, 0);
    clear_flag();
  endtask

  task automatic t_pulse(input logic lv);
    set_cfg(2'b11, lv ? 2'b10 : 2'b01);
    check("R5 idle level", chan_out, !lv);
    for (int i = 0; i <= 5; i++) tick(i, 1'b0, i == 0);
    check("R5 pulse level", chan_out, lv);
    idle_cyc(); idle_cyc();
    check("R5 held without tick", chan_out, lv);
    tick(6, 1'b0, 1'b0);
    check("R5 returns after one tick", chan_out, !lv);
    tick(7, 1'b0, 1'b0);
    check("R5 stays idle", chan_out, !lv);
    clear_flag();
  endtask

  task automatic t_pwm_edge(input int duty, input logic hi_true, input int exp);
    int n;
    write_val(duty);
    set_cfg(2'b10, hi_true ? 2'b10 : 2'b01);
    edge_period(9, hi_true, n);
    edge_period(9, hi_true, n);
    check($sformatf("R6 R8 edge duty %0d pol %0d", duty, hi_true), n, exp);
  endtask

  task automatic t_pwm_center(input int duty, input int exp);
    int n;
    cnt_updown = 1'b1;
    write_val(duty);
    set_cfg(2'b10, 2'b10);
    center_period(8, 1'b1, n);
    center_period(8, 1'b1, n);
    check($sformatf("R7 R8 center duty %0d", duty), n, exp);
    cnt_updown = 1'b0;
  endtask

  task automatic t_buffer();
    int n;
    write_val(3);
    set_cfg(2'b10, 2'b10);
    edge_period(9, 1'b1, n);
    for (int i = 0; i <= 4; i++) tick(i, 1'b0, i == 0);
    write_val(6);
    check("R9 value held mid period", chan_val, 3);
    for (int i = 5; i <= 9; i++) tick(i, 1'b0, 1'b0);
    check("R9 value held to boundary", chan_val, 3);
    tick(0, 1'b0, 1'b1);
    check("R9 value loaded at wrap", chan_val, 6);
    n = 1;
    for (int i = 1; i <= 9; i++) begin
      tick(i, 1'b0, 1'b0);
      if (chan_out) n++;
    end
    check("R9 new duty in effect", n, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_cyc();
    t_reset();
    t_capture();
    t_flag_irq();
    t_compare();
    t_pulse(1'b1);
    t_pulse(1'b0);
    t_pwm_edge(4, 1'b1, 4);
    t_pwm_edge(4, 1'b0, 4);
    t_pwm_edge(0, 1'b1, 0);
    t_pwm_edge(0, 1'b0, 0);
    t_pwm_edge(10, 1'b1, 10);
    t_pwm_edge(9, 1'b1, 9);
    t_pwm_center(3, 6);
    t_pwm_center(0, 0);
    t_pwm_center(8, 16);
    t_buffer();
    clear_flag();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule